// File: doc/BRIEF.md
# Flag-Setting Integer Execute Unit

This block is the combinational execute stage of a small 32-bit integer datapath. Each evaluation takes an opcode, two operands, a shift amount, a bitfield position and width, the four current condition flags and a set-flags control. It returns a result, a write-enable for that result, and the next value of each condition flag. Everything settles within one cycle. There is no internal state. The flags the caller supplies come back unchanged whenever an operation does not update them.

The operation set covers the following:
- add and subtract, each with and without the incoming carry
- the four bitwise logic operations, plus move and move-complement
- logical left and right shift, arithmetic right shift and rotate right, each by a programmable amount
- rotate right by one position through the carry flag
- compare-subtract, compare-add and test-AND, which set flags without writing a result
- insertion of a field into the first operand, and clearing of a field in it

Top module: `flag_alu`

## Requirements
- R1: Opcode encoding: ADD=0 gives a+b, ADC=1 gives a+b+c_in, SUB=2 gives a-b, SBC=3 gives a-b-1+c_in. All four assert wr_en.
- R2: For arithmetic and compare-arithmetic operations that update flags: N is result bit 31 and Z is set when the result is zero. C is the unsigned carry out; for subtraction C is 1 when no borrow occurs. V is set on two's-complement overflow.
- R3: AND=4 gives a&b, ORR=5 gives a|b, EOR=6 gives a^b, BIC=7 gives a&~b, MOV=8 gives b, MVN=9 gives ~b. When these update flags, only N and Z change, and C and V keep their inputs.
- R4: With set_flags=0, every opcode below 15 passes all four flag inputs to the flag outputs unchanged.
- R5: CMP=15 (a-b), CMN=16 (a+b) and TST=17 (a&b) hold wr_en low and update the flags whatever set_flags is. result carries the computed value. TST keeps C and V.
- R6: LSL=10, LSR=11 and ASR=12 shift a by sh_amt (0 to 31). LSL and LSR fill with zeros, and ASR fills with copies of a[31].
- R7: With flags updated by a shift or rotate and sh_amt nonzero, C is the last bit shifted out. With sh_amt zero, C is held. V is always held.
- R8: ROR=13 rotates a right by sh_amt. C becomes result bit 31 when sh_amt is nonzero.
- R9: RRX=14 gives {c_in, a[31:1]} regardless of sh_amt, and C becomes a[0] when flags are updated.
- R10: BFI=18 copies the low bf_width bits of b into a starting at bit bf_lsb. All other bits come from a.
- R11: BFC=19 clears bf_width bits of a starting at bit bf_lsb. All other bits come from a.
- R12: A bitfield operation with bf_width=0 or bf_lsb+bf_width>32 returns a unchanged. Bitfield operations always assert wr_en and never change any flag.
- R13: Opcodes 20 to 31 give result 0 and wr_en 0, and hold all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation select |
| a | input | 32 | First operand, shift source, bitfield destination |
| b | input | 32 | Second operand, bitfield source |
| sh_amt | input | 5 | Shift or rotate distance |
| bf_lsb | input | 5 | Lowest bit of the field |
| bf_width | input | 6 | Field width in bits |
| set_flags | input | 1 | Update flags for non-compare operations |
| n_in | input | 1 | Current negative flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| result | output | 32 | Operation result |
| wr_en | output | 1 | Result should be written back |
| n_out | output | 1 | Next negative flag |
| z_out | output | 1 | Next zero flag |
| c_out | output | 1 | Next carry flag |
| v_out | output | 1 | Next overflow flag |

## Verification
The bench builds the unit with its default WIDTH of 32. At that width, the operand corner values 0, 0xFFFFFFFF, 0x80000000 and 0x7FFFFFFF reach signed overflow, zero results and full-width borrow. The shift distance and field fields also span their full ranges, so a field ending exactly at bit 31 can be tested. Random opcodes, operands, distances, field positions and flag inputs are checked against a bit-serial reference model. Directed vectors cover zero-distance shifts, degenerate fields and unused opcodes.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int WIDTH = 32
) (
  input  logic [4:0]                   op,
  input  logic [WIDTH-1:0]             a,
  input  logic [WIDTH-1:0]             b,
  input  logic [$clog2(WIDTH)-1:0]     sh_amt,
  input  logic [$clog2(WIDTH)-1:0]     bf_lsb,
  input  logic [$clog2(WIDTH):0]       bf_width,
  input  logic                         set_flags,
  input  logic                         n_in,
  input  logic                         z_in,
  input  logic                         c_in,
  input  logic                         v_in,
  output logic [WIDTH-1:0]             result,
  output logic                         wr_en,
  output logic                         n_out,
  output logic                         z_out,
  output logic                         c_out,
  output logic                         v_out
);
  localparam int SHW = $clog2(WIDTH);
  localparam int BFW = SHW + 1;

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_ORR = 5'd5,  OP_EOR = 5'd6,  OP_BIC = 5'd7;
  localparam logic [4:0] OP_MOV = 5'd8,  OP_MVN = 5'd9,  OP_LSL = 5'd10, OP_LSR = 5'd11;
  localparam logic [4:0] OP_ASR = 5'd12, OP_ROR = 5'd13, OP_RRX = 5'd14, OP_CMP = 5'd15;
  localparam logic [4:0] OP_CMN = 5'd16, OP_TST = 5'd17, OP_BFI = 5'd18, OP_BFC = 5'd19;

  typedef enum logic [1:0] {FC_NONE, FC_ARITH, FC_NZ, FC_SHIFT} fclass_e;

  // adder shared by arithmetic and compare ops
  logic             inv_b;
  logic             cin;
  logic [WIDTH-1:0] bx;
  logic [WIDTH:0]   sum;
  logic             add_v;

  assign inv_b = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
  assign bx    = inv_b ? ~b : b;
  assign cin   = (op == OP_ADD || op == OP_CMN) ? 1'b0 :
                 (op == OP_SUB || op == OP_CMP) ? 1'b1 : c_in;
  assign sum   = {1'b0, a} + {1'b0, bx} + {{WIDTH{1'b0}}, cin};
  assign add_v = (a[WIDTH-1] == bx[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);

  // shifters with one guard bit to catch the carry
  logic        [WIDTH:0]       lsl_x;
  logic        [WIDTH:0]       lsr_x;
  logic signed [WIDTH:0]       asr_x;
  logic        [2*WIDTH-1:0]   ror_x;

  assign lsl_x = {1'b0, a} << sh_amt;
  assign lsr_x = {a, 1'b0} >> sh_amt;
  assign asr_x = $signed({a, 1'b0}) >>> sh_amt;
  assign ror_x = {a, a} >> sh_amt;

  // bitfield mask
  logic [BFW:0]     bf_top;
  logic             bf_ok;
  logic [WIDTH:0]   low_ones;
  logic [WIDTH-1:0] bf_mask;
  logic [WIDTH-1:0] bf_ins;
  logic [WIDTH-1:0] bf_clr;

  assign bf_top   = (BFW+1)'(bf_lsb) + (BFW+1)'(bf_width);
  assign bf_ok    = (bf_width != '0) && (bf_top <= (BFW+1)'(WIDTH));
  assign low_ones = ({{WIDTH{1'b0}}, 1'b1} << bf_width) - 1'b1;
  assign bf_mask  = bf_ok ? (low_ones[WIDTH-1:0] << bf_lsb) : '0;
  assign bf_ins   = (a & ~bf_mask) | ((b << bf_lsb) & bf_mask);
  assign bf_clr   = a & ~bf_mask;

  fclass_e fcls;
  logic    sh_c;
  logic    sh_force;
  logic    is_cmp;
  logic    upd;

  always_comb begin
    result   = '0;
    wr_en    = 1'b1;
    fcls     = FC_NONE;
    sh_c     = c_in;
    sh_force = 1'b0;
    is_cmp   = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin result = sum[WIDTH-1:0]; fcls = FC_ARITH; end
      OP_AND: begin result = a & b;  fcls = FC_NZ; end
      OP_ORR: begin result = a | b;  fcls = FC_NZ; end
      OP_EOR: begin result = a ^ b;  fcls = FC_NZ; end
      OP_BIC: begin result = a & ~b; fcls = FC_NZ; end
      OP_MOV: begin result = b;      fcls = FC_NZ; end
      OP_MVN: begin result = ~b;     fcls = FC_NZ; end
      OP_LSL: begin result = lsl_x[WIDTH-1:0]; sh_c = lsl_x[WIDTH]; fcls = FC_SHIFT; end
      OP_LSR: begin result = lsr_x[WIDTH:1];   sh_c = lsr_x[0];     fcls = FC_SHIFT; end
      OP_ASR: begin result = asr_x[WIDTH:1];   sh_c = asr_x[0];     fcls = FC_SHIFT; end
      OP_ROR: begin result = ror_x[WIDTH-1:0]; sh_c = ror_x[WIDTH-1]; fcls = FC_SHIFT; end
      OP_RRX: begin
        result = {c_in, a[WIDTH-1:1]}; sh_c = a[0]; sh_force = 1'b1; fcls = FC_SHIFT;
      end
      OP_CMP, OP_CMN: begin result = sum[WIDTH-1:0]; wr_en = 1'b0; is_cmp = 1'b1; fcls = FC_ARITH; end
      OP_TST: begin result = a & b; wr_en = 1'b0; is_cmp = 1'b1; fcls = FC_NZ; end
      OP_BFI: result = bf_ins;
      OP_BFC: result = bf_clr;
      default: wr_en = 1'b0;
    endcase
  end

  assign upd   = (fcls != FC_NONE) && (is_cmp || set_flags);
  assign n_out = upd ? result[WIDTH-1] : n_in;
  assign z_out = upd ? (result == '0) : z_in;
  assign c_out = !upd               ? c_in :
                 (fcls == FC_ARITH) ? sum[WIDTH] :
                 (fcls == FC_SHIFT && (sh_force || sh_amt != '0)) ? sh_c : c_in;
  assign v_out = (upd && fcls == FC_ARITH) ? add_v : v_in;
endmodule

module flag_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [4:0]       op,
  input logic [WIDTH-1:0] a,
  input logic             set_flags,
  input logic             n_in,
  input logic             z_in,
  input logic             c_in,
  input logic             v_in,
  input logic [WIDTH-1:0] result,
  input logic             wr_en,
  input logic             n_out,
  input logic             z_out,
  input logic             c_out,
  input logic             v_out
);
  logic hold;
  assign hold = (n_out == n_in) && (z_out == z_in) && (c_out == c_in) && (v_out == v_in);

  always_comb begin
    // R5
    cmp_no_write_chk: assert (!(op inside {5'd15, 5'd16, 5'd17}) || !wr_en);
    // R4
    quiet_flags_chk: assert (set_flags || op >= 5'd15 || hold);
    // R12
    bf_flags_chk: assert (!(op inside {5'd18, 5'd19}) || (hold && wr_en));
    // R3
    logic_v_chk: assert (!(op inside {[5'd4:5'd9], 5'd17}) || v_out == v_in);
    // R6
    asr_sign_chk: assert (op != 5'd12 || result[WIDTH-1] == a[WIDTH-1]);
    // R9
    rrx_top_chk: assert (op != 5'd14 || result[WIDTH-1] == c_in);
    // R13
    undef_op_chk: assert (op < 5'd20 || (!wr_en && result == '0 && hold));
  end
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .op(op), .a(a), .set_flags(set_flags),
  .n_in(n_in), .z_in(z_in), .c_in(c_in), .v_in(v_in),
  .result(result), .wr_en(wr_en),
  .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]  op;
  logic [31:0] a, b;
  logic [4:0]  sh_amt, bf_lsb;
  logic [5:0]  bf_width;
  logic        set_flags, n_in, z_in, c_in, v_in;
  logic [31:0] result;
  logic        wr_en, n_out, z_out, c_out, v_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  flag_alu u_dut (
    .op(op), .a(a), .b(b), .sh_amt(sh_amt), .bf_lsb(bf_lsb), .bf_width(bf_width),
    .set_flags(set_flags), .n_in(n_in), .z_in(z_in), .c_in(c_in), .v_in(v_in),
    .result(result), .wr_en(wr_en), .n_out(n_out), .z_out(z_out), .c_out(c_out), .v_out(v_out)
  );

  function automatic string tag_of(input logic [4:0] o);
    if (o <= 3) return "R1/R2";
    if (o <= 9) return "R3";
    if (o <= 12) return "R6/R7";
    if (o == 13) return "R8";
    if (o == 14) return "R9";
    if (o <= 17) return "R5";
    if (o == 18) return "R10/R12";
    if (o == 19) return "R11/R12";
    return "R13";
  endfunction

  task automatic model(output logic [31:0] r, output logic we, output logic [3:0] f);
    logic n = n_in, z = z_in, c = c_in, v = v_in;
    logic upd, nz, co;
    longint sa, sb, sr;
    logic [32:0] u;
    r = '0; we = 1'b1; upd = 1'b0; nz = 1'b0;
    case (op)
      0, 1, 2, 3, 15, 16: begin
        sa = longint'($signed(a)); sb = longint'($signed(b));
        case (op)
          0, 16: begin u = {1'b0, a} + {1'b0, b};         sr = sa + sb; end
          1:     begin u = {1'b0, a} + {1'b0, b} + c_in;  sr = sa + sb + c_in; end
          2, 15: begin u = {1'b0, a} - {1'b0, b};         sr = sa - sb; end
          default: begin u = {1'b0, a} - {1'b0, b} - (1 - c_in); sr = sa - sb - (1 - c_in); end
        endcase
        r = u[31:0];
        upd = set_flags || op >= 15; we = op < 15;
        if (upd) begin
          nz = 1'b1;
          if (op == 2 || op == 3 || op == 15) c = !u[32]; else c = u[32];
          v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        end
      end
      4, 17: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = a & ~b;
      8: r = b;
      9: r = ~b;
      10, 11, 12, 13: begin
        r = a; co = c_in;
        for (int i = 0; i < sh_amt; i++) begin
          if (op == 10) begin co = r[31]; r = {r[30:0], 1'b0}; end
          else if (op == 11) begin co = r[0]; r = {1'b0, r[31:1]}; end
          else if (op == 12) begin co = r[0]; r = {r[31], r[31:1]}; end
          else begin co = r[0]; r = {r[0], r[31:1]}; end
        end
        if (set_flags) begin nz = 1'b1; c = co; end
      end
      14: begin r = {c_in, a[31:1]}; if (set_flags) begin nz = 1'b1; c = a[0]; end end
      18, 19: begin
        r = a;
        if (bf_width != 0 && int'(bf_lsb) + int'(bf_width) <= 32)
          for (int i = 0; i < 32; i++)
            if (i >= bf_lsb && i < int'(bf_lsb) + int'(bf_width))
              r[i] = (op == 18) ? b[i - bf_lsb] : 1'b0;
      end
      default: we = 1'b0;
    endcase
    if (op inside {[4:9]} && set_flags) nz = 1'b1;
    if (op == 17) begin nz = 1'b1; we = 1'b0; end
    if (nz) begin n = r[31]; z = (r == 0); end
    f = {n, z, c, v};
  endtask

  task automatic run(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic [4:0] sa, input logic [4:0] lsb, input logic [5:0] w,
                     input logic s, input logic [3:0] fin, input string note);
    logic [31:0] er; logic ew; logic [3:0] ef;
    @(posedge clk); #1;
    op = o; a = x; b = y; sh_amt = sa; bf_lsb = lsb; bf_width = w; set_flags = s;
    {n_in, z_in, c_in, v_in} = fin;
    @(negedge clk);
    model(er, ew, ef);
    checks++;
    if (result !== er || wr_en !== ew || {n_out, z_out, c_out, v_out} !== ef) begin
      errors++;
      $display("FAIL %s %s op=%0d: got result=%h we=%b nzcv=%b, expected result=%h we=%b nzcv=%b",
               tag_of(o), note, o, result, wr_en, {n_out, z_out, c_out, v_out}, er, ew, ef);
    end
  endtask

  function automatic logic [31:0] pick(input int unsigned k);
    case (k % 6)
      0: return 32'h0;
      1: return 32'hFFFFFFFF;
      2: return 32'h80000000;
      3: return 32'h7FFFFFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    op = 5'd31; a = '0; b = '0; sh_amt = '0; bf_lsb = '0; bf_width = '0;
    set_flags = 1'b0; {n_in, z_in, c_in, v_in} = 4'b0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R13 idle state and unused opcodes
    run(5'd31, 32'h0, 32'h0, 0, 0, 0, 1, 4'b1010, "idle opcode");
    run(5'd20, 32'h1234, 32'h5678, 3, 0, 4, 1, 4'b0101, "unused opcode");
    // R1 R2 overflow and borrow corners
    run(5'd0, 32'h7FFFFFFF, 32'h1, 0, 0, 0, 1, 4'b0000, "R2 add overflow");
    run(5'd0, 32'hFFFFFFFF, 32'h1, 0, 0, 0, 1, 4'b0000, "R2 add carry zero");
    run(5'd2, 32'h0, 32'h1, 0, 0, 0, 1, 4'b0010, "R2 sub borrow");
    run(5'd2, 32'h80000000, 32'h1, 0, 0, 0, 1, 4'b0000, "R2 sub overflow");
    run(5'd3, 32'h5, 32'h5, 0, 0, 0, 1, 4'b0000, "R1 sbc no carry");
    run(5'd1, 32'hFFFFFFFF, 32'h0, 0, 0, 0, 1, 4'b0010, "R1 adc wrap");
    // R4 flags held without set_flags
    run(5'd0, 32'h7FFFFFFF, 32'h1, 0, 0, 0, 0, 4'b0110, "R4 add quiet");
    run(5'd10, 32'hFFFFFFFF, 32'h0, 4, 0, 0, 0, 4'b1001, "R4 shift quiet");
    // R5 compares update flags regardless of set_flags
    run(5'd15, 32'h5, 32'h5, 0, 0, 0, 0, 4'b1001, "R5 cmp equal");
    run(5'd16, 32'h80000000, 32'h80000000, 0, 0, 0, 0, 4'b0000, "R5 cmn overflow");
    run(5'd17, 32'hF0, 32'h0F, 0, 0, 0, 0, 4'b0011, "R5 tst zero");
    // R3 logical keeps C and V
    run(5'd9, 32'h0, 32'hFFFFFFFF, 0, 0, 0, 1, 4'b1011, "R3 mvn zero");
    run(5'd7, 32'hFFFFFFFF, 32'h0F0F0F0F, 0, 0, 0, 1, 4'b0000, "R3 bic");
    // R6 R7 shifts
    run(5'd12, 32'h80000000, 32'h0, 31, 0, 0, 1, 4'b0000, "R6 asr fill");
    run(5'd11, 32'h80000000, 32'h0, 31, 0, 0, 1, 4'b0000, "R6 lsr fill");
    run(5'd10, 32'h80000001, 32'h0, 1, 0, 0, 1, 4'b0001, "R7 lsl carry");
    run(5'd11, 32'h1, 32'h0, 0, 0, 0, 1, 4'b0010, "R7 zero amount");
    // R8 R9 rotates
    run(5'd13, 32'h1, 32'h0, 1, 0, 0, 1, 4'b0000, "R8 ror wrap");
    run(5'd14, 32'h3, 32'h0, 7, 0, 0, 1, 4'b0010, "R9 rrx");
    run(5'd14, 32'h2, 32'h0, 0, 0, 0, 0, 4'b0000, "R9 rrx quiet");
    // R10 R11 R12 bitfields
    run(5'd18, 32'h0, 32'hFFFFFFFF, 0, 3, 5, 1, 4'b0000, "R10 insert");
    run(5'd18, 32'h12345678, 32'hABCDEF01, 0, 16, 16, 1, 4'b1111, "R10 top field");
    run(5'd19, 32'hFFFFFFFF, 32'h0, 0, 7, 3, 1, 4'b0000, "R11 clear");
    run(5'd19, 32'hFFFFFFFF, 32'h0, 0, 0, 32, 1, 4'b0000, "R11 full clear");
    run(5'd18, 32'hCAFEF00D, 32'h0, 0, 30, 3, 1, 4'b0000, "R12 too wide");
    run(5'd19, 32'hCAFEF00D, 32'h0, 0, 4, 0, 1, 4'b0000, "R12 zero width");
    // random sweep
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] o;
      o = 5'($urandom_range(0, 21));
      run(o, pick($urandom), pick($urandom), 5'($urandom), 5'($urandom),
          6'($urandom_range(0, 33)), 1'($urandom), 4'($urandom), "random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule